// File: doc/BRIEF.md
# ADC Conversion Timing Generator

This block sequences one analog-to-digital conversion in time. A start pulse captures two 2-bit timing codes. The first code sets the length of the conversion clock in base time units, where one base unit is half a crystal period. The second code sets the sample clock as a power-of-two multiple of the conversion clock. The block then walks one conversion through its phases and drives the strobes that a converter data path needs: a sampling window, one strobe for each of the 14 successive-approximation steps, a result-load strobe, a calibration window and a done pulse.

Timing is counted in base units. The parameter `BASE_DIV` gives the number of system clock cycles in one base unit, and its default of 1 makes one system clock cycle equal to one base unit. Channel selection and the analog data path live outside the block.

Top module: `adc_conv_timer`

## Requirements
- R1: After reset, every output is low and the block is idle.
- R2: The conversion clock period `tcc` depends on `cc_sel_i`. Code 2'b00 gives 24 base units, 2'b11 gives 48 and 2'b10 gives 96. Step strobes within one conversion are spaced `tcc` apart.
- R3: The reserved conversion clock code 2'b01 produces exactly the timing of code 2'b00.
- R4: The sample clock `tsc` depends on `sc_sel_i`. Codes 2'b00, 2'b01, 2'b10 and 2'b11 give 1, 2, 4 and 8 times `tcc`. `sample_en_o` is high for 2·`tsc` base units, starting in the first cycle after the edge that accepts the start.
- R5: The phases follow a fixed order: sampling, then the step strobes, then the result-load strobe, then calibration, then done. No two of the five outputs are ever high in the same cycle.
- R6: Exactly 14 single-cycle step strobes occur in each conversion. Each one falls on the last cycle of its `tcc` period, and the first falls `tcc` after sampling ends.
- R7: `load_stb_o` pulses once, on the last of 4 base units that follow the 14th step. Measured from the accepting edge, it falls 14·`tcc` + 2·`tsc` + 4 base units later, which is 388 at the fastest codes.
- R8: `cal_act_o` is high for 4·`tcc` base units, beginning in the cycle right after the load strobe.
- R9: `done_o` is a one-cycle pulse in the cycle after calibration ends. A start seen in idle or during that done cycle is accepted, and sampling begins in the next cycle.
- R10: A start pulse that arrives while a conversion is in progress (sampling through calibration) is ignored. It adds no second conversion and does not move `done_o`.
- R11: Both codes are captured when a start is accepted. If the code inputs change later in the conversion, that conversion's timing does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a conversion |
| cc_sel_i | input | 2 | Conversion clock code |
| sc_sel_i | input | 2 | Sample clock code |
| sample_en_o | output | 1 | High during the sampling window |
| step_stb_o | output | 1 | One-cycle strobe at the end of each conversion step |
| load_stb_o | output | 1 | One-cycle strobe to load the result |
| cal_act_o | output | 1 | High during the calibration cycle |
| done_o | output | 1 | One-cycle pulse when the conversion is complete |

## Verification
The following are checked on every cycle:
- The five outputs are mutually exclusive.
- A sampling window opens only after a start.
- Step strobes never fall on adjacent cycles.
- Exactly 14 step strobes precede each load strobe.
- Calibration follows the load strobe directly.
- Done follows calibration.
- A start during calibration cannot break the sequence.

The directed scenarios cover the things a single-cycle property cannot show:
- The exact lengths of each window for every code pair, including the reserved code and the 388-unit fastest total.
- That codes are captured at the start.
- That a start held across done gives back-to-back conversions.

// File: rtl/adc_tg_pkg.sv
package adc_tg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_STEP,
        PH_LOAD,
        PH_CAL,
        PH_DONE
    } phase_e;

    // Conversion clock codes; the reserved code falls back to the fast setting
    localparam logic [1:0] CC_FAST = 2'b00;
    localparam logic [1:0] CC_RSVD = 2'b01;
    localparam logic [1:0] CC_SLOW = 2'b10;
    localparam logic [1:0] CC_MID  = 2'b11;

endpackage

// File: rtl/adc_tg_prescale.sv
module adc_tg_prescale #(
    parameter int BASE_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

    logic [PW-1:0] div_d, div_q;

    assign tick_o = run_i && (div_q == PW'(BASE_DIV - 1));

    always_comb begin
        div_d = div_q;
        if (!run_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/adc_tg_decode.sv
module adc_tg_decode
    import adc_tg_pkg::*;
#(
    parameter int CC_FAST_U = 24,
    parameter int CC_MID_U  = 48,
    parameter int CC_SLOW_U = 96,
    parameter int CAL_CLKS  = 4,
    parameter int CNT_W     = 12
) (
    input  logic [1:0]       cc_code_i,
    input  logic [1:0]       sc_code_i,
    output logic [CNT_W-1:0] tcc_len_o,
    output logic [CNT_W-1:0] smp_len_o,
    output logic [CNT_W-1:0] cal_len_o
);
    logic [CNT_W-1:0] tsc_len;

    always_comb begin
        unique case (cc_code_i)
            CC_SLOW: tcc_len_o = CNT_W'(CC_SLOW_U);
            CC_MID:  tcc_len_o = CNT_W'(CC_MID_U);
            default: tcc_len_o = CNT_W'(CC_FAST_U);
        endcase
        tsc_len   = tcc_len_o << sc_code_i;
        smp_len_o = tsc_len << 1;
        cal_len_o = CNT_W'(tcc_len_o * CNT_W'(CAL_CLKS));
    end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_tg_pkg::*;
#(
    parameter int BASE_DIV  = 1,
    parameter int CC_FAST_U = 24,
    parameter int CC_MID_U  = 48,
    parameter int CC_SLOW_U = 96,
    parameter int N_STEPS   = 14,
    parameter int XFER_U    = 4,
    parameter int CAL_CLKS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] cc_sel_i,
    input  logic [1:0] sc_sel_i,
    output logic       sample_en_o,
    output logic       step_stb_o,
    output logic       load_stb_o,
    output logic       cal_act_o,
    output logic       done_o
);
    localparam int MAX_SMP = 16 * CC_SLOW_U;
    localparam int MAX_CAL = CAL_CLKS * CC_SLOW_U;
    localparam int MAX_LEN = (MAX_SMP > MAX_CAL) ? MAX_SMP : MAX_CAL;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
        logic [1:0]        cc;
        logic [1:0]        sc;
    } tg_state_t;

    tg_state_t s_d, s_q;

    logic             tick;
    logic             run;
    logic             cnt_zero;
    logic [CNT_W-1:0] tcc_len, smp_len, cal_len;
    logic [CNT_W-1:0] new_tcc, new_smp, new_cal;

    assign run      = (s_q.phase != PH_IDLE) && (s_q.phase != PH_DONE);
    assign cnt_zero = (s_q.cnt == '0);

    adc_tg_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    // Lengths for the running conversion (captured codes)
    adc_tg_decode #(
        .CC_FAST_U (CC_FAST_U), .CC_MID_U (CC_MID_U), .CC_SLOW_U (CC_SLOW_U),
        .CAL_CLKS  (CAL_CLKS),  .CNT_W    (CNT_W)
    ) u_dec_run (
        .cc_code_i (s_q.cc),
        .sc_code_i (s_q.sc),
        .tcc_len_o (tcc_len),
        .smp_len_o (smp_len),
        .cal_len_o (cal_len)
    );

    // Lengths for a conversion being launched (live codes)
    adc_tg_decode #(
        .CC_FAST_U (CC_FAST_U), .CC_MID_U (CC_MID_U), .CC_SLOW_U (CC_SLOW_U),
        .CAL_CLKS  (CAL_CLKS),  .CNT_W    (CNT_W)
    ) u_dec_new (
        .cc_code_i (cc_sel_i),
        .sc_code_i (sc_sel_i),
        .tcc_len_o (new_tcc),
        .smp_len_o (new_smp),
        .cal_len_o (new_cal)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE, PH_DONE: begin
                s_d.phase = PH_IDLE;
                if (start_i) begin
                    s_d.phase = PH_SAMPLE;
                    s_d.cc    = cc_sel_i;
                    s_d.sc    = sc_sel_i;
                    s_d.cnt   = new_smp - CNT_W'(1);
                    s_d.step  = '0;
                end
            end
            PH_SAMPLE: begin
                if (tick) begin
                    if (cnt_zero) begin
                        s_d.phase = PH_STEP;
                        s_d.cnt   = tcc_len - CNT_W'(1);
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            PH_STEP: begin
                if (tick) begin
                    if (cnt_zero) begin
                        if (s_q.step == STEP_W'(N_STEPS - 1)) begin
                            s_d.phase = PH_LOAD;
                            s_d.cnt   = CNT_W'(XFER_U - 1);
                        end else begin
                            s_d.step = s_q.step + STEP_W'(1);
                            s_d.cnt  = tcc_len - CNT_W'(1);
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            PH_LOAD: begin
                if (tick) begin
                    if (cnt_zero) begin
                        s_d.phase = PH_CAL;
                        s_d.cnt   = cal_len - CNT_W'(1);
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            PH_CAL: begin
                if (tick) begin
                    if (cnt_zero) begin
                        s_d.phase = PH_DONE;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, step: '0, cc: '0, sc: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_en_o = (s_q.phase == PH_SAMPLE);
    assign step_stb_o  = (s_q.phase == PH_STEP) && tick && cnt_zero;
    assign load_stb_o  = (s_q.phase == PH_LOAD) && tick && cnt_zero;
    assign cal_act_o   = (s_q.phase == PH_CAL);
    assign done_o      = (s_q.phase == PH_DONE);

    // Live-code lengths other than the sample window are not needed at launch
    logic unused_new;
    assign unused_new = ^{new_tcc, new_cal};
endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk #(
    parameter int N_STEPS = 14
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic sample_en_o,
    input logic step_stb_o,
    input logic load_stb_o,
    input logic cal_act_o,
    input logic done_o
);
    logic [7:0] steps_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_seen <= '0;
        end else if (sample_en_o) begin
            steps_seen <= '0;
        end else if (step_stb_o) begin
            steps_seen <= steps_seen + 8'd1;
        end
    end

    AST_OUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_en_o, step_stb_o, load_stb_o, cal_act_o, done_o})); // R5

    AST_SAMPLE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en_o) |-> $past(start_i)); // R9

    AST_STEP_NOT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb_o |=> !step_stb_o); // R6

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_o |-> (steps_seen == 8'(N_STEPS))); // R6

    AST_CAL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_o |=> cal_act_o); // R8

    AST_DONE_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cal_act_o)); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_act_o && start_i) |=> (cal_act_o || done_o)); // R10
endmodule

bind adc_conv_timer adc_conv_timer_chk #(.N_STEPS(N_STEPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sample_en_o (sample_en_o),
    .step_stb_o  (step_stb_o),
    .load_stb_o  (load_stb_o),
    .cal_act_o   (cal_act_o),
    .done_o      (done_o)
);

// File: tb/adc_conv_timer_bench.sv
`timescale 1ns/1ps
module adc_conv_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cc_sel = 2'b00;
    logic [1:0] sc_sel = 2'b00;
    logic       sample_en, step_stb, load_stb, cal_act, done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_conv_timer u_adc_conv_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cc_sel_i    (cc_sel),
        .sc_sel_i    (sc_sel),
        .sample_en_o (sample_en),
        .step_stb_o  (step_stb),
        .load_stb_o  (load_stb),
        .cal_act_o   (cal_act),
        .done_o      (done)
    );

    function automatic int tcc_units(input logic [1:0] c);
        case (c)
            2'b10:   return 96;
            2'b11:   return 48;
            default: return 24;
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: act=%0d exp=%0d", rq, what, act, exp);
        end
    endtask

    // One conversion, measured cycle by cycle (cycle 1 = first after the accepting edge)
    task automatic run_conv(input logic [1:0] cc, input logic [1:0] sc,
                            input bit mod_codes, input bit poke, input string name);
        int tcc, tsc, t_ld, lim;
        int n_smp, f_smp, n_stp, f_stp, l_stp, gap_bad, n_ld, c_ld, n_cal, f_cal, n_dn, c_dn;
        tcc = tcc_units(cc);
        tsc = tcc << sc;
        t_ld = 14 * tcc + 2 * tsc + 4;
        lim = t_ld + 4 * tcc + 6;
        n_smp = 0; f_smp = -1; n_stp = 0; f_stp = -1; l_stp = -1; gap_bad = 0;
        n_ld = 0; c_ld = -1; n_cal = 0; f_cal = -1; n_dn = 0; c_dn = -1;
        @(negedge clk);
        cc_sel = cc; sc_sel = sc; start = 1'b1;
        @(posedge clk);
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (sample_en) begin n_smp++; if (f_smp < 0) f_smp = c; end
            if (step_stb) begin
                if (l_stp >= 0 && c - l_stp != tcc) gap_bad++;
                n_stp++; if (f_stp < 0) f_stp = c; l_stp = c;
            end
            if (load_stb) begin n_ld++; c_ld = c; end
            if (cal_act) begin n_cal++; if (f_cal < 0) f_cal = c; end
            if (done) begin n_dn++; c_dn = c; end
            if (mod_codes && c == 3) begin cc_sel = ~cc; sc_sel = ~sc; end
            if (poke) start = (c == 2 * tsc + 5) || (c == t_ld + 2);
        end
        start = 1'b0;
        chk("R4", {name, " sample length"}, n_smp, 2 * tsc);
        chk("R4", {name, " sample begins"}, f_smp, 1);
        chk("R6", {name, " step count"}, n_stp, 14);
        chk("R6", {name, " first step"}, f_stp, 2 * tsc + tcc);
        chk("R2", {name, " step spacing errors"}, gap_bad, 0);
        chk("R2", {name, " last step"}, l_stp, 2 * tsc + 14 * tcc);
        chk("R7", {name, " load count"}, n_ld, 1);
        chk("R7", {name, " load cycle"}, c_ld, t_ld);
        chk("R8", {name, " cal length"}, n_cal, 4 * tcc);
        chk("R8", {name, " cal begins"}, f_cal, t_ld + 1);
        chk("R9", {name, " done count"}, n_dn, 1);
        chk("R9", {name, " done cycle"}, c_dn, t_ld + 4 * tcc + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "outputs after reset",
            int'({sample_en, step_stb, load_stb, cal_act, done}), 0);
    endtask

    task automatic t_fastest();
        run_conv(2'b00, 2'b00, 1'b0, 1'b0, "fast");
        chk("R7", "fastest total base units", 14 * 24 + 2 * 24 + 4, 388);
    endtask

    task automatic t_slowest();
        run_conv(2'b10, 2'b11, 1'b0, 1'b0, "slow");
    endtask

    task automatic t_mid();
        run_conv(2'b11, 2'b01, 1'b0, 1'b0, "mid");
    endtask

    task automatic t_reserved();
        // R3: code 01 expected with 24-unit timing
        run_conv(2'b01, 2'b10, 1'b0, 1'b0, "R3 reserved");
    endtask

    task automatic t_capture();
        // R11: codes flipped at cycle 3, timing must stay that of the launch codes
        run_conv(2'b00, 2'b01, 1'b1, 1'b0, "R11 capture");
    endtask

    task automatic t_busy_start();
        // R10: start pulses during steps and calibration change nothing
        run_conv(2'b11, 2'b00, 1'b0, 1'b1, "R10 busy start");
    endtask

    task automatic t_back_to_back();
        int first_dn, second_dn, smp_after;
        first_dn = -1; second_dn = -1; smp_after = 0;
        @(negedge clk);
        cc_sel = 2'b00; sc_sel = 2'b00; start = 1'b1;
        @(posedge clk);
        for (int c = 1; c <= 1100; c++) begin
            @(negedge clk);
            if (done) begin
                if (first_dn < 0) first_dn = c; else if (second_dn < 0) second_dn = c;
            end
            if (first_dn > 0 && c == first_dn + 1) begin
                smp_after = int'(sample_en);
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk("R10", "held start: first done", first_dn, 485);
        chk("R9", "start in done cycle restarts sampling", smp_after, 1);
        chk("R9", "second done", second_dn, 970);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fastest();
        t_slowest();
        t_mid();
        t_reserved();
        t_capture();
        t_busy_start();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: act=expired exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule